// File: doc/BRIEF.md
# EPP Cycle Gating and Timeout Unit

This block fronts an enhanced parallel port for a host. It keeps the port's data latch, control register and a sticky transfer-timeout flag, and it runs address and data handshakes with the peripheral. A handshake starts only if the control register holds the exact line pattern that the requested direction needs. Otherwise the access is dropped without touching the cable.

Each byte handshake raises an address or data strobe and waits for the peripheral's wait line to go high and then low again. If either phase takes too long, the transfer fails. The failure sets the timeout flag, and that flag appears in bit 0 of every status read. Wide accesses at the data port are sent as several byte handshakes, lowest byte first. The host issues one access at a time as a `host_req` pulse and must wait for the `host_done` pulse before issuing the next.

Top module: `epp_access_unit`

## Requirements
- R1: After reset the following hold. A control read returns 0xCC and a data read returns 0xFF. Status bit 0 reads 0. Both strobes and `host_done` are low.
- R2: A write at offset 3 (address port) or offset 4 (data port) starts a handshake only when the control bits selected by mask 0x2F equal 0x04. Any other value gives no strobe, but `host_done` still pulses.
- R3: A read at offset 3 or 4 starts a handshake only when the masked control equals 0x24. A rejected read returns all ones at the access width: 0xFF for a byte, 0xFFFF for a half, 0xFFFFFFFF for a word.
- R4: An offset-3 write raises `epp_astb` with `epp_wr` high and the byte on `pad_dout`. `epp_astb` and `epp_dstb` are never high together.
- R5: At offset 4, `host_size` 0 moves 1 byte, 1 moves 2 bytes and 2 or 3 moves 4 bytes. Bytes go lowest-order first, and each byte is held on `pad_dout` for the whole strobe.
- R6: If the wait line has not risen by the TIMEOUT_CYCLES-th strobe cycle, the byte fails. An acknowledge seen in that last cycle still counts as success. A failure sets the timeout flag. A status read (offset 1) returns `{stat_in[7:1], flag}`.
- R7: The timeout flag is sticky. Successful transfers leave it set. Only a status write with bit 0 = 1 clears it; a status write with bit 0 = 0 leaves it set.
- R8: After the first failed byte, the remaining bytes of the access get no strobe. On a read, bytes that were not received come back as 0xFF.
- R9: A control write (offset 2) whose value OR 0xC0 equals the stored control gives no `ctrl_upd` pulse. A data write (offset 0) equal to the latched byte gives no `data_upd` pulse.
- R10: Control bits 7:6 always read 1. When a control write flips bit 5 (direction), `dir_chg` pulses with the new `pad_dir` one cycle before `ctrl_upd` pulses.
- R11: A data read returns `pad_din` when control bit 5 is 1 and the latched byte when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | 0 byte, 1 half, 2/3 word |
| host_wdata | input | 32 | Write data |
| host_done | output | 1 | One-cycle access completion |
| host_rdata | output | 32 | Read data, valid with host_done |
| stat_in | input | 7 | Peripheral status lines for status bits 7:1 |
| ctrl_lines | output | 4 | Control register bits 3:0 to the pads |
| ctrl_upd | output | 1 | Pulse when a new control value is applied |
| pad_dir | output | 1 | Data pad direction, 1 = input |
| dir_chg | output | 1 | Pulse when the direction bit changes |
| pad_dout | output | 8 | Byte driven on the data pads |
| data_upd | output | 1 | Pulse when the data latch changes |
| pad_din | input | 8 | Byte read from the data pads |
| epp_astb | output | 1 | Address strobe |
| epp_dstb | output | 1 | Data strobe |
| epp_wr | output | 1 | High for the whole of a write transfer |
| epp_wait | input | 1 | Peripheral wait/acknowledge |

## Verification
Two events can land in the same cycle: the strobe-timeout expiry and the peripheral's acknowledge. The bench's peripheral model delays its acknowledge by a programmable number of cycles. A delay of TIMEOUT_CYCLES-2 makes the acknowledge reach the unit exactly in the last allowed strobe cycle, and the bench expects success with the flag left clear. One cycle more must fail and set the flag. Both outcomes are judged from the status read and the strobe count.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] CTRL_CMP_MASK = 8'h2F;
  localparam logic [7:0] CTRL_PAT_WR   = 8'h04;
  localparam logic [7:0] CTRL_PAT_RD   = 8'h24;
  localparam logic [7:0] CTRL_FIXED    = 8'hC0;
  localparam logic [7:0] CTRL_RESET    = 8'hCC;
  localparam int         CTRL_DIR_BIT  = 5;

  typedef enum logic [1:0] {E_IDLE, E_STB, E_REL} eng_st_t;
  typedef enum logic [1:0] {T_IDLE, T_CTL, T_XFER} top_st_t;
endpackage

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int NBW = $clog2(HOST_BYTES + 1)
) (
  input  logic [7:0]     ctrl,
  input  logic           we,
  input  logic [2:0]     offset,
  input  logic [1:0]     size,
  output logic           is_epp,
  output logic           is_addr,
  output logic           ok,
  output logic [NBW-1:0] nbytes
);
  localparam int NB_HALF = (HOST_BYTES >= 2) ? 2 : HOST_BYTES;
  localparam int NB_WORD = (HOST_BYTES >= 4) ? 4 : HOST_BYTES;

  logic [7:0] pattern;

  always_comb begin
    is_addr = (offset == OFF_EADDR);
    is_epp  = is_addr || (offset == OFF_EDATA);
    pattern = we ? CTRL_PAT_WR : CTRL_PAT_RD;
    ok      = is_epp && ((ctrl & CTRL_CMP_MASK) == pattern);
    if (is_addr) begin
      nbytes = NBW'(1);
    end else begin
      case (size)
        2'd0:    nbytes = NBW'(1);
        2'd1:    nbytes = NBW'(NB_HALF);
        default: nbytes = NBW'(NB_WORD);
      endcase
    end
  end
endmodule

// File: rtl/epp_read_mux.sv
module epp_read_mux
  import epp_pkg::*;
(
  input  logic [2:0] offset,
  input  logic [7:0] ctrl_q,
  input  logic [7:0] data_q,
  input  logic [7:0] pad_din,
  input  logic [7:1] stat_in,
  input  logic       to_flag,
  output logic [7:0] byte_o
);
  always_comb begin
    case (offset)
      OFF_DATA: byte_o = ctrl_q[CTRL_DIR_BIT] ? pad_din : data_q;
      OFF_STAT: byte_o = {stat_in, to_flag};
      OFF_CTRL: byte_o = ctrl_q;
      default:  byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int HOST_BYTES = 4,
  parameter int NBW = $clog2(HOST_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    is_addr,
  input  logic                    is_write,
  input  logic [NBW-1:0]          nbytes,
  input  logic [HOST_BYTES*8-1:0] wdata,
  input  logic                    wait_in,
  input  logic [7:0]              pad_din,
  output logic                    addr_stb,
  output logic                    data_stb,
  output logic                    xfer_write,
  output logic [7:0]              xfer_byte,
  output logic                    finish,
  output logic                    fail,
  output logic [HOST_BYTES*8-1:0] rbuf
);
  localparam int HW = HOST_BYTES * 8;
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int IW = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1;
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYCLES - 1);

  eng_st_t        st;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx, last;
  logic [HW-1:0]  wbuf;
  logic           sel_addr;

  assign xfer_byte = wbuf[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= E_IDLE;
      cnt        <= '0;
      idx        <= '0;
      last       <= '0;
      wbuf       <= '0;
      rbuf       <= '1;
      sel_addr   <= 1'b0;
      addr_stb   <= 1'b0;
      data_stb   <= 1'b0;
      xfer_write <= 1'b0;
      finish     <= 1'b0;
      fail       <= 1'b0;
    end else begin
      finish <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            idx        <= '0;
            last       <= IW'(nbytes - NBW'(1));
            wbuf       <= wdata;
            rbuf       <= '1;
            fail       <= 1'b0;
            cnt        <= '0;
            sel_addr   <= is_addr;
            addr_stb   <= is_addr;
            data_stb   <= !is_addr;
            xfer_write <= is_write;
            st         <= E_STB;
          end
        end
        E_STB: begin
          if (wait_in) begin
            if (!xfer_write) rbuf[{idx, 3'b000} +: 8] <= pad_din;
            addr_stb <= 1'b0;
            data_stb <= 1'b0;
            cnt      <= '0;
            st       <= E_REL;
          end else if (cnt == LIM) begin
            addr_stb   <= 1'b0;
            data_stb   <= 1'b0;
            fail       <= 1'b1;
            finish     <= 1'b1;
            xfer_write <= 1'b0;
            st         <= E_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        E_REL: begin
          if (!wait_in) begin
            if (idx == last) begin
              finish     <= 1'b1;
              xfer_write <= 1'b0;
              st         <= E_IDLE;
            end else begin
              idx      <= idx + IW'(1);
              wbuf     <= wbuf >> 8;
              addr_stb <= sel_addr;
              data_stb <= !sel_addr;
              cnt      <= '0;
              st       <= E_STB;
            end
          end else if (cnt == LIM) begin
            fail       <= 1'b1;
            finish     <= 1'b1;
            xfer_write <= 1'b0;
            st         <= E_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_access_unit.sv
module epp_access_unit
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int HOST_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_req,
  input  logic                    host_we,
  input  logic [2:0]              host_addr,
  input  logic [1:0]              host_size,
  input  logic [HOST_BYTES*8-1:0] host_wdata,
  output logic                    host_done,
  output logic [HOST_BYTES*8-1:0] host_rdata,
  input  logic [7:1]              stat_in,
  output logic [3:0]              ctrl_lines,
  output logic                    ctrl_upd,
  output logic                    pad_dir,
  output logic                    dir_chg,
  output logic [7:0]              pad_dout,
  output logic                    data_upd,
  input  logic [7:0]              pad_din,
  output logic                    epp_astb,
  output logic                    epp_dstb,
  output logic                    epp_wr,
  input  logic                    epp_wait
);
  localparam int HW  = HOST_BYTES * 8;
  localparam int NBW = $clog2(HOST_BYTES + 1);

  top_st_t        st;
  logic [7:0]     ctrl_q, pend_ctrl, data_q;
  logic           dir_q, to_q;
  logic [HW-1:0]  cur_mask;
  logic           cur_read;

  logic           g_is_epp, g_is_addr, g_ok;
  logic [NBW-1:0] g_nbytes;
  logic [7:0]     rd_byte, new_ctrl;
  logic           eng_start, eng_finish, eng_fail;
  logic [7:0]     eng_byte;
  logic [HW-1:0]  eng_rbuf;

  function automatic logic [HW-1:0] ones_mask(input logic [NBW-1:0] n);
    logic [HW-1:0] m;
    m = '0;
    for (int i = 0; i < HOST_BYTES; i++) begin
      if (i < int'(n)) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  epp_cycle_gate #(.HOST_BYTES(HOST_BYTES), .NBW(NBW)) u_gate (
    .ctrl(ctrl_q), .we(host_we), .offset(host_addr), .size(host_size),
    .is_epp(g_is_epp), .is_addr(g_is_addr), .ok(g_ok), .nbytes(g_nbytes)
  );

  epp_read_mux u_rmux (
    .offset(host_addr), .ctrl_q(ctrl_q), .data_q(data_q), .pad_din(pad_din),
    .stat_in(stat_in), .to_flag(to_q), .byte_o(rd_byte)
  );

  assign eng_start = (st == T_IDLE) && host_req && g_ok;

  epp_byte_engine #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .HOST_BYTES(HOST_BYTES), .NBW(NBW)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .is_addr(g_is_addr),
    .is_write(host_we), .nbytes(g_nbytes), .wdata(host_wdata),
    .wait_in(epp_wait), .pad_din(pad_din),
    .addr_stb(epp_astb), .data_stb(epp_dstb), .xfer_write(epp_wr),
    .xfer_byte(eng_byte), .finish(eng_finish), .fail(eng_fail), .rbuf(eng_rbuf)
  );

  assign new_ctrl   = host_wdata[7:0] | CTRL_FIXED;
  assign ctrl_lines = ctrl_q[3:0];
  assign pad_dir    = dir_q;
  assign pad_dout   = epp_wr ? eng_byte : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= T_IDLE;
      ctrl_q     <= CTRL_RESET;
      pend_ctrl  <= CTRL_RESET;
      dir_q      <= CTRL_RESET[CTRL_DIR_BIT];
      data_q     <= 8'hFF;
      to_q       <= 1'b0;
      cur_mask   <= '0;
      cur_read   <= 1'b0;
      host_done  <= 1'b0;
      host_rdata <= '0;
      ctrl_upd   <= 1'b0;
      dir_chg    <= 1'b0;
      data_upd   <= 1'b0;
    end else begin
      host_done <= 1'b0;
      ctrl_upd  <= 1'b0;
      dir_chg   <= 1'b0;
      data_upd  <= 1'b0;
      case (st)
        T_IDLE: begin
          if (host_req) begin
            if (g_is_epp) begin
              if (g_ok) begin
                cur_mask <= ones_mask(g_nbytes);
                cur_read <= !host_we;
                st       <= T_XFER;
              end else begin
                host_done  <= 1'b1;
                host_rdata <= host_we ? '0 : ones_mask(g_nbytes);
              end
            end else if (host_we) begin
              host_rdata <= '0;
              case (host_addr)
                OFF_DATA: begin
                  host_done <= 1'b1;
                  if (host_wdata[7:0] != data_q) begin
                    data_q   <= host_wdata[7:0];
                    data_upd <= 1'b1;
                  end
                end
                OFF_STAT: begin
                  host_done <= 1'b1;
                  if (host_wdata[0]) to_q <= 1'b0;
                end
                OFF_CTRL: begin
                  if (new_ctrl == ctrl_q) begin
                    host_done <= 1'b1;
                  end else if (new_ctrl[CTRL_DIR_BIT] != ctrl_q[CTRL_DIR_BIT]) begin
                    dir_q     <= new_ctrl[CTRL_DIR_BIT];
                    dir_chg   <= 1'b1;
                    pend_ctrl <= new_ctrl;
                    st        <= T_CTL;
                  end else begin
                    ctrl_q    <= new_ctrl;
                    ctrl_upd  <= 1'b1;
                    host_done <= 1'b1;
                  end
                end
                default: host_done <= 1'b1;
              endcase
            end else begin
              host_done  <= 1'b1;
              host_rdata <= {{(HW-8){1'b0}}, rd_byte};
            end
          end
        end
        T_CTL: begin
          ctrl_q    <= pend_ctrl;
          ctrl_upd  <= 1'b1;
          host_done <= 1'b1;
          st        <= T_IDLE;
        end
        T_XFER: begin
          if (eng_finish) begin
            if (eng_fail) to_q <= 1'b1;
            host_rdata <= cur_read ? (eng_rbuf & cur_mask) : '0;
            host_done  <= 1'b1;
            st         <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_access_unit_chk.sv
module epp_access_unit_chk #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       host_done,
  input logic [3:0] ctrl_lines,
  input logic       ctrl_upd,
  input logic       pad_dir,
  input logic       dir_chg,
  input logic [7:0] pad_dout,
  input logic       epp_astb,
  input logic       epp_dstb,
  input logic       epp_wr
);
  logic        stb;
  logic [31:0] hi_cnt;
  logic        seen_clk;

  assign stb = epp_astb || epp_dstb;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      seen_clk <= 1'b0;
    end else begin
      seen_clk <= 1'b1;
      hi_cnt   <= stb ? hi_cnt + 32'd1 : 32'd0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !seen_clk |-> (!epp_astb && !epp_dstb && !host_done));

  assert_write_pattern_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb) && epp_wr) |-> (ctrl_lines == 4'h4 && !pad_dir));

  assert_read_pattern_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb) && !epp_wr) |-> (ctrl_lines == 4'h4 && pad_dir));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({epp_astb, epp_dstb}));

  assert_byte_held_R5: assert property (@(posedge clk) disable iff (rst)
    (stb && epp_wr && $past(stb)) |-> $stable(pad_dout));

  assert_strobe_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    stb |-> (hi_cnt < TIMEOUT_CYCLES));

  assert_dir_before_ctrl_R10: assert property (@(posedge clk) disable iff (rst)
    dir_chg |=> ctrl_upd);
endmodule

bind epp_access_unit epp_access_unit_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .host_done(host_done), .ctrl_lines(ctrl_lines),
  .ctrl_upd(ctrl_upd), .pad_dir(pad_dir), .dir_chg(dir_chg),
  .pad_dout(pad_dout), .epp_astb(epp_astb), .epp_dstb(epp_dstb),
  .epp_wr(epp_wr)
);

// File: tb/epp_access_unit_tb.sv
`timescale 1ns/1ps
module epp_access_unit_tb;
  localparam int TO = 16;
  localparam int VW = 81;
  localparam int NV = 11;

  // {ctrl[80:73], we[72], addr[71:69], size[68:67], wdata[66:35], strobes[34:32], exp_rd[31:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h04, 1'b1, 3'd3, 2'd0, 32'h0000_00A5, 3'd1, 32'h0},
    {8'h04, 1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF, 3'd4, 32'h0},
    {8'h0C, 1'b1, 3'd4, 2'd0, 32'h0000_0033, 3'd0, 32'h0},
    {8'h24, 1'b1, 3'd4, 2'd0, 32'h0000_0044, 3'd0, 32'h0},
    {8'h24, 1'b0, 3'd4, 2'd2, 32'h0,         3'd4, 32'h4433_2211},
    {8'h24, 1'b0, 3'd4, 2'd1, 32'h0,         3'd2, 32'h0000_2211},
    {8'h04, 1'b0, 3'd3, 2'd0, 32'h0,         3'd0, 32'h0000_00FF},
    {8'h04, 1'b0, 3'd4, 2'd1, 32'h0,         3'd0, 32'h0000_FFFF},
    {8'h25, 1'b0, 3'd4, 2'd2, 32'h0,         3'd0, 32'hFFFF_FFFF},
    {8'h34, 1'b0, 3'd3, 2'd0, 32'h0,         3'd1, 32'h0000_0011},
    {8'hC4, 1'b1, 3'd3, 2'd0, 32'h0000_005C, 3'd1, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_done;
  logic [31:0] host_rdata;
  logic [7:1]  stat_in = 7'h50;
  logic [3:0]  ctrl_lines;
  logic        ctrl_upd, pad_dir, dir_chg, data_upd;
  logic [7:0]  pad_dout, pad_din;
  logic        epp_astb, epp_dstb, epp_wr;
  logic        epp_wait = 1'b0;

  int checks = 0, failures = 0;

  logic        clr_log = 1'b0;
  int          allowed = 1000;
  int          ack_delay = 0;
  int          log_n = 0, rises = 0, rd_k = 0, dly = 0, cyc = 0;
  int          n_ctrl = 0, n_data = 0, cyc_dir = 0, cyc_ctrl = 0;
  logic [7:0]  log_byte [4];
  logic        log_addr [4];
  logic        stb_d = 1'b0;
  logic [7:0]  rd_bytes [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  logic        stb;

  assign stb     = epp_astb | epp_dstb;
  assign pad_din = rd_bytes[rd_k[1:0]];

  always #2 clk = ~clk;

  epp_access_unit #(.TIMEOUT_CYCLES(TO), .HOST_BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_done(host_done), .host_rdata(host_rdata), .stat_in(stat_in),
    .ctrl_lines(ctrl_lines), .ctrl_upd(ctrl_upd), .pad_dir(pad_dir),
    .dir_chg(dir_chg), .pad_dout(pad_dout), .data_upd(data_upd),
    .pad_din(pad_din), .epp_astb(epp_astb), .epp_dstb(epp_dstb),
    .epp_wr(epp_wr), .epp_wait(epp_wait)
  );

  // peripheral model and event recorder
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    stb_d <= stb;
    if (ctrl_upd) begin n_ctrl <= n_ctrl + 1; cyc_ctrl <= cyc; end
    if (dir_chg)  cyc_dir <= cyc;
    if (data_upd) n_data <= n_data + 1;
    if (clr_log) begin
      log_n <= 0; rises <= 0; rd_k <= 0; dly <= 0;
    end else begin
      if (stb && !stb_d) rises <= rises + 1;
      if (!stb) begin
        dly <= 0;
        if (epp_wait) begin epp_wait <= 1'b0; rd_k <= rd_k + 1; end
      end else begin
        dly <= dly + 1;
        if (!epp_wait && dly >= ack_delay && log_n < allowed) begin
          epp_wait <= 1'b1;
          if (log_n < 4) begin
            log_byte[log_n] <= pad_dout;
            log_addr[log_n] <= epp_astb;
          end
          log_n <= log_n + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    for (int k = 0; k < 300 && !host_done; k++) @(negedge clk);
    rd = host_rdata;
    if (!host_done) check(1'b0, "done-missing", 32'h0, 32'h1);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [VW-1:0] v;
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!epp_astb && !epp_dstb && !host_done, "R1 quiet", {29'b0, epp_astb, epp_dstb, host_done}, 32'h0);
    access(1'b0, 3'd2, 2'd0, 32'h0, rd); check(rd == 32'hCC, "R1 ctrl", rd, 32'hCC);
    access(1'b0, 3'd0, 2'd0, 32'h0, rd); check(rd == 32'hFF, "R1 data", rd, 32'hFF);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd); check(rd == 32'hA0, "R1 status", rd, 32'hA0);

    // table walk: gating, widths, rejected read values (R2 R3 R5)
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      access(1'b1, 3'd2, 2'd0, {24'h0, v[80:73]}, rd);
      clear_log();
      access(v[72], v[71:69], v[68:67], v[66:35], rd);
      check(rises == int'(v[34:32]), v[72] ? "R2 strobes" : "R3 strobes", rises, v[34:32]);
      if (!v[72]) check(rd == v[31:0], "R3 rdata", rd, v[31:0]);
    end

    // R4 address write byte and strobe kind
    access(1'b1, 3'd2, 2'd0, 32'h04, rd);
    clear_log();
    access(1'b1, 3'd3, 2'd0, 32'h6B, rd);
    check(log_n == 1 && log_addr[0] && log_byte[0] == 8'h6B, "R4 addr write", {23'b0, log_addr[0], log_byte[0]}, 32'h16B);

    // R5 byte order of a word write
    clear_log();
    access(1'b1, 3'd4, 2'd2, 32'hA1B2C3D4, rd);
    check(log_n == 4 && !log_addr[0], "R5 count", log_n, 4);
    check({log_byte[3], log_byte[2], log_byte[1], log_byte[0]} == 32'hA1B2C3D4, "R5 order",
          {log_byte[3], log_byte[2], log_byte[1], log_byte[0]}, 32'hA1B2C3D4);

    // R6 acknowledge in the last allowed cycle still succeeds
    ack_delay = TO - 2;
    clear_log();
    access(1'b1, 3'd3, 2'd0, 32'h12, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'hA0, "R6 late ack ok", rd, 32'hA0);
    // one cycle later fails
    ack_delay = TO - 1;
    clear_log();
    access(1'b1, 3'd3, 2'd0, 32'h13, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'hA1, "R6 timeout flag", rd, 32'hA1);
    ack_delay = 0;

    // R6 no acknowledge at all, status other bits from stat_in
    allowed = 0;
    stat_in = 7'h40;
    clear_log();
    access(1'b1, 3'd4, 2'd0, 32'h77, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'h81, "R6 status merge", rd, 32'h81);

    // R7 sticky flag
    allowed = 1000;
    clear_log();
    access(1'b1, 3'd4, 2'd0, 32'h78, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'h81, "R7 survives success", rd, 32'h81);
    access(1'b1, 3'd1, 2'd0, 32'hFE, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'h81, "R7 bit0=0 keeps", rd, 32'h81);
    access(1'b1, 3'd1, 2'd0, 32'h01, rd);
    access(1'b0, 3'd1, 2'd0, 32'h0, rd);
    check(rd == 32'h80, "R7 clear", rd, 32'h80);

    // R8 abort after the first failed byte of a word read
    access(1'b1, 3'd2, 2'd0, 32'h24, rd);
    allowed = 2;
    clear_log();
    access(1'b0, 3'd4, 2'd2, 32'h0, rd);
    check(rd == 32'hFFFF2211, "R8 partial data", rd, 32'hFFFF2211);
    check(rises == 3, "R8 aborted bytes", rises, 3);
    allowed = 1000;
    access(1'b1, 3'd1, 2'd0, 32'h01, rd);

    // R11 data read follows direction
    clear_log();
    access(1'b0, 3'd0, 2'd0, 32'h0, rd);
    check(rd == 32'h11, "R11 pad input", rd, 32'h11);

    // R10 direction change ordering
    access(1'b1, 3'd2, 2'd0, 32'h04, rd);
    check(cyc_ctrl == cyc_dir + 1 && !pad_dir, "R10 order", cyc_ctrl - cyc_dir, 1);
    access(1'b0, 3'd2, 2'd0, 32'h0, rd);
    check(rd == 32'hC4, "R10 fixed bits", rd, 32'hC4);

    // R9 redundant writes, R11 latched data
    access(1'b1, 3'd0, 2'd0, 32'h5A, rd);
    n0 = n_data;
    access(1'b1, 3'd0, 2'd0, 32'h5A, rd);
    check(n_data == n0, "R9 data same", n_data, n0);
    access(1'b0, 3'd0, 2'd0, 32'h0, rd);
    check(rd == 32'h5A, "R11 latched", rd, 32'h5A);
    n0 = n_ctrl;
    access(1'b1, 3'd2, 2'd0, 32'hC4, rd);
    check(n_ctrl == n0, "R9 ctrl same", n_ctrl, n0);
    access(1'b1, 3'd2, 2'd0, 32'h05, rd);
    check(n_ctrl == n0 + 1 && ctrl_lines == 4'h5, "R9 ctrl change", n_ctrl, n0 + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule